// File: doc/BRIEF.md
# Serial Amplifier Control Register Receiver

This block receives one 8-bit control word for an audio amplifier over a three-wire, write-only serial link made of an active-high enable, a serial clock and a data line. All three lines are brought into a fast system clock domain through synchroniser flops, and the edges of the serial clock and of the enable are found from the synchronised samples. While the enable is high, each rising serial-clock edge shifts in one bit, least significant bit first. A new word reaches the holding register only when the enable falls after all eight bits have arrived.

The held word is split into an output-mode field and a volume code. The block decodes the mode into per-output source selections and shutdown flags for a speaker output and a right/left headphone pair. It decodes the volume code into a signed gain in half-dB steps. A one-cycle pulse marks each cycle in which a new word is loaded. After reset the block shuts down every output and sets the gain to 0 dB.

Top module: `amp_serial_ctl`

## Requirements
- R1: After reset the mode is 0, the volume code is 27 (binary 11011), the gain is 0 half-dB, every output is shut down and no load pulse is present.
- R2: The first bit shifted in becomes word bit 0. Word bits 2..0 form the mode and word bits 7..3 form the volume code.
- R3: The held settings change only in the cycle that follows a detected falling enable, and only if exactly 8 bits were captured in that transfer. While a transfer is in progress the old settings stay on the outputs.
- R4: Once 8 bits are captured, further serial-clock edges and data are discarded until the enable goes low. The first 8 bits are the ones loaded.
- R5: A transfer whose enable falls after fewer than 8 bits loads nothing, and the previous settings remain.
- R6: Serial-clock edges seen while the enable is low are not captured and change no output.
- R7: gain_hdb is the signed value 3 × volume code − 81, in units of 0.5 dB, so it runs from −81 (code 0) to +12 (code 31).
- R8: Each source field is 3 bits {phone, right, left}. The decode gives {speaker, right, left} as follows. Mode 0: 000,000,000. Mode 1: 100,000,000. Mode 2: 000,100,100. Mode 3: 011,000,000. Mode 4: 000,010,001. Mode 5: 111,000,000. Mode 6: 110,110,101. Mode 7: 100,110,101. An output's off flag is 1 exactly when its source field is 000.
- R9: word_loaded is high for exactly one cycle per loaded word, in the same cycle that the new settings first appear on the outputs.
- R10: A rising enable clears the bit count and the shift register, so an aborted transfer leaves nothing behind for the next one.
- R11: If a rising serial-clock edge and a falling enable show up in the same synchronised sample, that clock edge is not captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | Serial enable, active high, asynchronous |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| out_mode | output | 3 | Held output-mode field |
| vol_code | output | 5 | Held volume code |
| gain_hdb | output | 8 | Signed gain in half-dB steps |
| spk_src | output | 3 | Speaker sources {phone, right, left} |
| rgt_src | output | 3 | Right output sources {phone, right, left} |
| lft_src | output | 3 | Left output sources {phone, right, left} |
| spk_off | output | 1 | Speaker shut down |
| rgt_off | output | 1 | Right output shut down |
| lft_off | output | 1 | Left output shut down |
| word_loaded | output | 1 | One-cycle pulse when a word is loaded |

## Verification
Two events can land on the same synchronised sample: a rising serial-clock edge and a falling enable. When that clock edge would have been the eighth bit, the outcome decides whether a word is loaded at all. The bench provokes this by changing both lines on the same system-clock edge at the end of a 7-bit transfer. Its reference model then expects the edge to be dropped and the transfer to be aborted, so the old settings stay and no load pulse appears. The companion case is a rising enable together with a clock edge, where the clear wins. The model is compared against every output on every cycle, so a one-cycle slip in either ordering is reported.

// File: rtl/amp_ctl_pkg.sv
package amp_ctl_pkg;

    localparam int WORD_W  = 8;
    localparam int MODE_W  = 3;
    localparam int VOL_W   = 5;
    localparam int SRC_W   = 3;
    localparam int NUM_OUT = 3;
    localparam int GAIN_W  = 8;
    localparam int CNT_W   = $clog2(WORD_W + 1);
    localparam int HDB_STEP   = 3;
    localparam int HDB_OFFSET = 81;

    localparam logic [VOL_W-1:0] VOL_RESET = VOL_W'(27);

    // source bit positions inside a source field
    localparam int SRC_PHONE = 2;
    localparam int SRC_RIGHT = 1;
    localparam int SRC_LEFT  = 0;

    typedef logic [SRC_W-1:0] src_sel_t;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF        = 3'd0,
        MODE_PH_SPK     = 3'd1,
        MODE_PH_HP      = 3'd2,
        MODE_ST_SPK     = 3'd3,
        MODE_ST_HP      = 3'd4,
        MODE_ALL_SPK    = 3'd5,
        MODE_MIX_ALL    = 3'd6,
        MODE_PH_SPK_MIX = 3'd7
    } out_mode_e;

    typedef struct packed {
        logic [VOL_W-1:0] vol;
        out_mode_e        mode;
    } ctl_word_t;

    typedef struct packed {
        src_sel_t spk;
        src_sel_t rgt;
        src_sel_t lft;
    } route_t;

    localparam src_sel_t S_P = src_sel_t'(1 << SRC_PHONE);
    localparam src_sel_t S_R = src_sel_t'(1 << SRC_RIGHT);
    localparam src_sel_t S_L = src_sel_t'(1 << SRC_LEFT);
    localparam src_sel_t S_0 = '0;

    function automatic route_t decode_mode(input out_mode_e m);
        route_t r;
        case (m)
            MODE_OFF:        r = '{spk: S_0,             rgt: S_0,       lft: S_0};
            MODE_PH_SPK:     r = '{spk: S_P,             rgt: S_0,       lft: S_0};
            MODE_PH_HP:      r = '{spk: S_0,             rgt: S_P,       lft: S_P};
            MODE_ST_SPK:     r = '{spk: S_R | S_L,       rgt: S_0,       lft: S_0};
            MODE_ST_HP:      r = '{spk: S_0,             rgt: S_R,       lft: S_L};
            MODE_ALL_SPK:    r = '{spk: S_P | S_R | S_L, rgt: S_0,       lft: S_0};
            MODE_MIX_ALL:    r = '{spk: S_R | S_P,       rgt: S_R | S_P, lft: S_L | S_P};
            MODE_PH_SPK_MIX: r = '{spk: S_P,             rgt: S_R | S_P, lft: S_L | S_P};
            default:         r = '{spk: S_0,             rgt: S_0,       lft: S_0};
        endcase
        return r;
    endfunction

    function automatic logic signed [GAIN_W-1:0] vol_to_hdb(input logic [VOL_W-1:0] v);
        int g;
        g = HDB_STEP * int'(v) - HDB_OFFSET;
        return GAIN_W'(g);
    endfunction

endpackage

// File: rtl/amp_in_sync.sv
module amp_in_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/amp_ser_shift.sv
module amp_ser_shift
    import amp_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_s,
    input  logic              sck_s,
    input  logic              dat_s,
    output logic              commit,
    output logic [WORD_W-1:0] word
);
    logic             en_d;
    logic             sck_d;
    logic [CNT_W-1:0] cnt;
    logic [WORD_W-1:0] sh;
    logic             en_rise;
    logic             en_fall;
    logic             sck_rise;
    logic             full;

    assign en_rise  = en_s & ~en_d;
    assign en_fall  = ~en_s & en_d;
    assign sck_rise = sck_s & ~sck_d;
    assign full     = (cnt == CNT_W'(WORD_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d  <= 1'b0;
            sck_d <= 1'b0;
            cnt   <= '0;
            sh    <= '0;
        end else begin
            en_d  <= en_s;
            sck_d <= sck_s;
            if (en_rise) begin
                cnt <= '0;
                sh  <= '0;
            end else if (en_s && sck_rise && !full) begin
                sh  <= {dat_s, sh[WORD_W-1:1]};
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign commit = en_fall & full;
    assign word   = sh;
endmodule

// File: rtl/amp_ctl_hold.sv
module amp_ctl_hold
    import amp_ctl_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     commit,
    input  logic [WORD_W-1:0]        word,
    output ctl_word_t                held,
    output logic                     pulse,
    output route_t                   route,
    output logic signed [GAIN_W-1:0] gain
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '{vol: VOL_RESET, mode: MODE_OFF};
            pulse <= 1'b0;
        end else begin
            pulse <= commit;
            if (commit) held <= ctl_word_t'(word);
        end
    end

    assign route = decode_mode(held.mode);
    assign gain  = vol_to_hdb(held.vol);
endmodule

// File: rtl/amp_serial_ctl.sv
module amp_serial_ctl
    import amp_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ser_en,
    input  logic                     ser_clk,
    input  logic                     ser_dat,
    output logic [MODE_W-1:0]        out_mode,
    output logic [VOL_W-1:0]         vol_code,
    output logic signed [GAIN_W-1:0] gain_hdb,
    output logic [SRC_W-1:0]         spk_src,
    output logic [SRC_W-1:0]         rgt_src,
    output logic [SRC_W-1:0]         lft_src,
    output logic                     spk_off,
    output logic                     rgt_off,
    output logic                     lft_off,
    output logic                     word_loaded
);
    localparam int IN_W = 3;

    logic [IN_W-1:0]   raw_in;
    logic [IN_W-1:0]   syn_in;
    logic              commit;
    logic [WORD_W-1:0] word;
    ctl_word_t         held;
    route_t            route;
    src_sel_t          src  [NUM_OUT];
    logic [NUM_OUT-1:0] off;

    assign raw_in = {ser_en, ser_clk, ser_dat};

    amp_in_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (syn_in)
    );

    amp_ser_shift u_shift (
        .clk    (clk),
        .rst    (rst),
        .en_s   (syn_in[2]),
        .sck_s  (syn_in[1]),
        .dat_s  (syn_in[0]),
        .commit (commit),
        .word   (word)
    );

    amp_ctl_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .word   (word),
        .held   (held),
        .pulse  (word_loaded),
        .route  (route),
        .gain   (gain_hdb)
    );

    assign src[2] = route.spk;
    assign src[1] = route.rgt;
    assign src[0] = route.lft;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_off
        assign off[i] = (src[i] == '0);
    end

    assign out_mode = held.mode;
    assign vol_code = held.vol;
    assign spk_src  = src[2];
    assign rgt_src  = src[1];
    assign lft_src  = src[0];
    assign spk_off  = off[2];
    assign rgt_off  = off[1];
    assign lft_off  = off[0];
endmodule

// File: rtl/amp_serial_ctl_chk.sv
module amp_serial_ctl_chk
    import amp_ctl_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     ser_en,
    input logic                     ser_clk,
    input logic                     ser_dat,
    input logic [MODE_W-1:0]        out_mode,
    input logic [VOL_W-1:0]         vol_code,
    input logic signed [GAIN_W-1:0] gain_hdb,
    input logic [SRC_W-1:0]         spk_src,
    input logic [SRC_W-1:0]         rgt_src,
    input logic [SRC_W-1:0]         lft_src,
    input logic                     spk_off,
    input logic                     rgt_off,
    input logic                     lft_off,
    input logic                     word_loaded
);
    p_pulse_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        word_loaded |=> !word_loaded);

    p_hold_without_load_r3: assert property (@(posedge clk) disable iff (rst)
        !word_loaded |-> $stable({out_mode, vol_code}));

    // R3: a load follows a falling enable seen through the default two-flop synchroniser
    p_load_after_fall_r3: assert property (@(posedge clk) disable iff (rst)
        word_loaded |-> ($past(ser_en, 4) && !$past(ser_en, 3)));

    p_mode0_all_off_r8: assert property (@(posedge clk) disable iff (rst)
        (out_mode == 3'd0) |-> (spk_off && rgt_off && lft_off));

    p_gain_bounds_r7: assert property (@(posedge clk) disable iff (rst)
        (gain_hdb >= -8'sd81) && (gain_hdb <= 8'sd12));

    p_gain_tracks_vol_r7: assert property (@(posedge clk) disable iff (rst)
        $stable(vol_code) |-> $stable(gain_hdb));
endmodule

bind amp_serial_ctl amp_serial_ctl_chk u_chk (.*);

// File: tb/amp_serial_ctl_bench.sv
module amp_serial_ctl_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_en = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic [2:0] out_mode;
    logic [4:0] vol_code;
    logic signed [7:0] gain_hdb;
    logic [2:0] spk_src, rgt_src, lft_src;
    logic spk_off, rgt_off, lft_off, word_loaded;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    amp_serial_ctl u_amp_serial_ctl (
        .clk(clk), .rst(rst), .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .out_mode(out_mode), .vol_code(vol_code), .gain_hdb(gain_hdb),
        .spk_src(spk_src), .rgt_src(rgt_src), .lft_src(lft_src),
        .spk_off(spk_off), .rgt_off(rgt_off), .lft_off(lft_off),
        .word_loaded(word_loaded)
    );

    // reference model state
    logic [2:0] hist[$];
    int         m_cnt = 0;
    logic [7:0] m_sh = '0;
    logic [7:0] m_hold = 8'b11011_000;
    bit         m_pulse = 0;
    int         m_loads = 0;
    int         dut_loads = 0;

    function automatic logic [8:0] exp_routes(input logic [2:0] m);
        case (m)
            3'd0: return 9'b000_000_000;
            3'd1: return 9'b100_000_000;
            3'd2: return 9'b000_100_100;
            3'd3: return 9'b011_000_000;
            3'd4: return 9'b000_010_001;
            3'd5: return 9'b111_000_000;
            3'd6: return 9'b110_110_101;
            default: return 9'b100_110_101;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [2:0] cur, prv;
        if (rst) begin
            hist = {3'b000, 3'b000, 3'b000, 3'b000};
            m_cnt = 0; m_sh = '0; m_hold = 8'b11011_000; m_pulse = 0;
        end else begin
            hist.push_back({ser_en, ser_clk, ser_dat});
            void'(hist.pop_front());
            cur = hist[1];
            prv = hist[0];
            m_pulse = 0;
            if (cur[2] && !prv[2]) begin
                m_cnt = 0; m_sh = '0;
            end else if (cur[2] && cur[1] && !prv[1] && m_cnt < 8) begin
                m_sh[m_cnt] = cur[0];
                m_cnt++;
            end
            if (!cur[2] && prv[2] && m_cnt == 8) begin
                m_hold = m_sh; m_pulse = 1; m_loads++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle compare against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [8:0] r;
            r = exp_routes(m_hold[2:0]);
            if (word_loaded) dut_loads++;
            chk("R2 R3 mode", out_mode, m_hold[2:0]);
            chk("R2 R3 volume", vol_code, m_hold[7:3]);
            chk("R7 gain", gain_hdb, 3 * int'(m_hold[7:3]) - 81);
            chk("R8 routes", {spk_src, rgt_src, lft_src}, r);
            chk("R8 off flags", {spk_off, rgt_off, lft_off},
                {r[8:6] == 3'b0, r[5:3] == 3'b0, r[2:0] == 3'b0});
            chk("R9 load pulse", word_loaded, m_pulse);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // send n bits LSB first; coincide=1 makes the last clock rise with the enable fall
    task automatic send(input logic [15:0] bits, input int n, input bit coincide);
        @(negedge clk); ser_en = 1'b1;
        idle(4);
        for (int i = 0; i < n; i++) begin
            ser_dat = bits[i]; ser_clk = 1'b0;
            idle(4);
            if (coincide && i == n - 1) begin
                ser_clk = 1'b1; ser_en = 1'b0;
                idle(4);
                ser_clk = 1'b0;
            end else begin
                ser_clk = 1'b1;
                idle(4);
                ser_clk = 1'b0;
            end
        end
        if (!coincide) begin
            idle(4);
            ser_en = 1'b0;
        end
        idle(10);
    endtask

    task automatic expect_ctl(input string tag, input int m, input int v);
        chk({tag, " mode"}, out_mode, m);
        chk({tag, " volume"}, vol_code, v);
        chk({tag, " gain"}, gain_hdb, 3 * v - 81);
    endtask

    initial begin
        idle(5);
        @(negedge clk); rst = 1'b0;
        idle(3);
        // R1: reset state
        expect_ctl("R1 reset", 0, 27);
        chk("R1 gain 0dB", gain_hdb, 0);
        chk("R1 all off", {spk_off, rgt_off, lft_off}, 3'b111);
        chk("R1 no pulse", word_loaded, 0);

        // R2/R3: plain word, vol 22 mode 5
        send(16'h00B5, 8, 0);
        expect_ctl("R2 R3 word", 5, 22);

        // R4: eleven bits, only the first eight count
        send(16'h04FE, 11, 0);
        expect_ctl("R4 excess bits", 6, 31);
        chk("R7 top gain", gain_hdb, 12);

        // R5: short transfer aborted
        send(16'h0000, 5, 0);
        expect_ctl("R5 short abort", 6, 31);

        // R6: clock toggles with enable low
        for (int i = 0; i < 6; i++) begin
            ser_dat = i[0]; ser_clk = 1'b1; idle(4); ser_clk = 1'b0; idle(4);
        end
        idle(6);
        expect_ctl("R6 idle clocks", 6, 31);

        // R10: after an abort a fresh transfer starts from a clean count
        send(16'h00FF, 3, 0);
        send(16'h0000, 8, 0);
        expect_ctl("R10 clean restart", 0, 0);
        chk("R7 bottom gain", gain_hdb, -81);

        // R11: eighth clock edge coincides with enable fall: aborted
        send(16'h00FF, 8, 1);
        expect_ctl("R11 coincident edge", 0, 0);

        // R8: every mode
        for (int m = 0; m < 8; m++) begin
            send(16'((m * 4 + 1) * 8 + m), 8, 0);
            expect_ctl("R8 mode sweep", m, m * 4 + 1);
            chk("R8 route sweep", {spk_src, rgt_src, lft_src}, exp_routes(3'(m)));
        end

        // R9: exactly one pulse per loaded word
        chk("R9 pulse count", dut_loads, m_loads);
        chk("R9 expected loads", m_loads, 11);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule